// File: doc/BRIEF.md
# Acquisition Timing Engine with Delayed Start Trigger

This block is the timing engine of a digital capture channel. It runs on its own sample clock, separate from the clock of the pattern generator. It samples a parallel input bus and, once armed, waits for a start condition. It then captures a configured number of samples, presenting each on an output bus together with a one-cycle valid strobe. After the last sample a done flag rises and stays high until the engine is armed again.

The engine has two start sources. The first is the rising edge of an external trigger pin. The second is the generator's "data active" flag. This flag is routed on chip and delayed by a programmable whole number of sample-clock cycles before it is used as a start condition. The delay compensates for the round-trip latency of an external loop, such as cables, a device under test and the return path. With the delay set to the loop latency, the first captured sample is the first sample the generator sent.

The input bus can be sampled on the rising or the falling clock edge. Falling-edge sampling places the sampling point midway between generator transitions. The delayed-flag start cannot be used while the sample clock is derived from a returned strobe. An arm request that combines the two is refused and raises a sticky configuration-error flag.

Top module: `acq_engine`

## Requirements
- R1: While reset is asserted and after reset is released, cap_valid_o, done_o and cfg_err_o are 0 until the first arm request.
- R2: With src_sel_i = 1 (delayed data-active source), the first captured sample is the bus value from the input cycle in which gen_active_i, delayed by dly_cycles_i cycles, is first high while armed. In a loop of latency N with dly_cycles_i = N, a ramp sent from 0 is captured starting at exactly 0.
- R3: The delay accepts every value from 0 to 15. A value of 0 adds no cycles beyond the fixed input register, so it aligns with a loop latency of 0, and 15 aligns with a latency of 15.
- R4: With src_sel_i = 0 (external source), capture starts with the bus sample taken in the input cycle where ext_trig_i goes from 0 to 1.
- R5: After the start condition, exactly cap_len_i samples (latched at arm) appear on cap_data_o, one per clock cycle in consecutive cycles, each with cap_valid_o = 1.
- R6: done_o rises in the cycle after the last valid sample and stays at 1 until an accepted arm. arm_i is a single-cycle pulse, taken only when the engine is idle or done. An accepted arm clears done_o at the next clock edge.
- R7: A capture length of 0 makes done_o rise after the start condition without any valid sample.
- R8: An arm request with src_sel_i = 1 and strobe_clk_i = 1 sets cfg_err_o. The request is refused, with no capture and no done. cfg_err_o stays 1 until reset, even across later valid captures.
- R9: fall_edge_i = 1 samples the bus on the falling clock edge and fall_edge_i = 0 on the rising edge. For bus data held for a whole cycle, both settings capture the same samples with the same alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Acquisition sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm request, single-cycle pulse |
| src_sel_i | input | 1 | Start source: 0 external trigger, 1 delayed data-active |
| strobe_clk_i | input | 1 | 1 = sample clock derived from returned strobe |
| fall_edge_i | input | 1 | 1 = sample the bus on the falling clock edge |
| dly_cycles_i | input | DLY_W (4) | Delay of the data-active flag in clock cycles |
| cap_len_i | input | LEN_W (8) | Number of samples to capture |
| smp_data_i | input | DATA_W (8) | Parallel input data bus |
| gen_active_i | input | 1 | Raw data-active flag from the generator |
| ext_trig_i | input | 1 | External start trigger |
| cap_data_o | output | DATA_W (8) | Captured sample |
| cap_valid_o | output | 1 | Captured sample valid strobe |
| done_o | output | 1 | Capture complete, held until re-armed |
| cfg_err_o | output | 1 | Sticky configuration-error flag |

## Verification
The properties assume that arm_i is a single-cycle pulse and that the configuration inputs are stable in the cycle an arm is accepted. The sample count property relies on cap_len_i being latched at that arm and on the count restarting there. The stimulus holds arm_i high for exactly one clock edge and changes configuration only while the engine is idle or done. Bus data and triggers change only well after a rising edge, so both edge settings see data that is stable for the whole cycle. Generator activity stops and the delay line drains before each new capture, so no run starts on a stale delayed flag.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } acq_state_e;

    typedef enum logic {
        SRC_EXT        = 1'b0,
        SRC_DLY_ACTIVE = 1'b1
    } acq_src_e;

endpackage

// File: rtl/acq_sampler.sv
`timescale 1ns/1ps
// Input register stage: bus sampled on the chosen edge, flag and trigger registered.
module acq_sampler #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fall_edge_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              act_i,
    input  logic              ext_i,
    output logic [DATA_W-1:0] data_o,
    output logic              act_o,
    output logic              ext_rise_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              act;
        logic              ext;
        logic              ext_prev;
    } smp_t;

    smp_t              r_d, r_q;
    logic [DATA_W-1:0] neg_q;

    // falling-edge capture, handed to the rising-edge stage half a cycle later
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) neg_q <= '0;
        else         neg_q <= data_i;
    end

    always_comb begin
        r_d          = r_q;
        r_d.data     = fall_edge_i ? neg_q : data_i;
        r_d.act      = act_i;
        r_d.ext      = ext_i;
        r_d.ext_prev = r_q.ext;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign data_o     = r_q.data;
    assign act_o      = r_q.act;
    assign ext_rise_o = r_q.ext & ~r_q.ext_prev;
endmodule

// File: rtl/acq_delay_line.sv
`timescale 1ns/1ps
// Whole-cycle delay of the registered data-active flag, tap chosen by sel_i.
module acq_delay_line #(
    parameter int MAX_DELAY = 15,
    localparam int DLY_W = $clog2(MAX_DELAY + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             act_i,
    input  logic [DLY_W-1:0] sel_i,
    output logic             act_o
);
    logic [MAX_DELAY-1:0] line_d, line_q;

    generate
        if (MAX_DELAY == 1) begin : g_single
            assign line_d = act_i;
        end else begin : g_chain
            assign line_d = {line_q[MAX_DELAY-2:0], act_i};
        end
    endgenerate

    always_comb begin
        act_o = act_i;
        for (int k = 0; k < MAX_DELAY; k++) begin
            if (sel_i == DLY_W'(k + 1)) act_o = line_q[k];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) line_q <= '0;
        else         line_q <= line_d;
    end
endmodule

// File: rtl/acq_ctrl.sv
`timescale 1ns/1ps
// Arm / trigger / capture / done sequencing.
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              arm_i,
    input  logic              src_sel_i,
    input  logic              strobe_clk_i,
    input  logic [DLY_W-1:0]  dly_cycles_i,
    input  logic [LEN_W-1:0]  cap_len_i,
    input  logic [DATA_W-1:0] smp_i,
    input  logic              ext_rise_i,
    input  logic              dly_act_i,
    output logic [DLY_W-1:0]  dly_sel_o,
    output logic [DATA_W-1:0] cap_data_o,
    output logic              cap_valid_o,
    output logic              done_o,
    output logic              cfg_err_o,
    output acq_state_e        state_o
);
    typedef struct packed {
        acq_state_e        state;
        acq_src_e          src;
        logic [DLY_W-1:0]  dly;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              err;
    } ctl_t;

    ctl_t r_d, r_q;
    logic conflict, can_arm, accept, trig;

    assign conflict = (acq_src_e'(src_sel_i) == SRC_DLY_ACTIVE) && strobe_clk_i;
    assign can_arm  = (r_q.state == ST_IDLE) || (r_q.state == ST_DONE);
    assign accept   = arm_i && can_arm && !conflict;
    assign trig     = (r_q.src == SRC_EXT) ? ext_rise_i : dly_act_i;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (arm_i && conflict) begin
                    r_d.err = 1'b1;
                end else if (accept) begin
                    r_d.state = ST_ARMED;
                    r_d.src   = acq_src_e'(src_sel_i);
                    r_d.dly   = dly_cycles_i;
                    r_d.len   = cap_len_i;
                    r_d.cnt   = '0;
                end
            end
            ST_ARMED: begin
                if (trig) begin
                    if (r_q.len == '0) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.valid = 1'b1;
                        r_d.data  = smp_i;
                        r_d.cnt   = LEN_W'(1);
                        r_d.state = (r_q.len == LEN_W'(1)) ? ST_DONE : ST_CAPTURE;
                    end
                end
            end
            ST_CAPTURE: begin
                r_d.valid = 1'b1;
                r_d.data  = smp_i;
                r_d.cnt   = r_q.cnt + LEN_W'(1);
                if (r_d.cnt == r_q.len) r_d.state = ST_DONE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        // done trails entry into ST_DONE by one cycle, so it follows the last valid
        r_d.done = (r_q.state == ST_DONE) && !accept;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.src   <= SRC_EXT;
        end else begin
            r_q <= r_d;
        end
    end

    assign dly_sel_o   = r_q.dly;
    assign cap_data_o  = r_q.data;
    assign cap_valid_o = r_q.valid;
    assign done_o      = r_q.done;
    assign cfg_err_o   = r_q.err;
    assign state_o     = r_q.state;
endmodule

// File: rtl/acq_engine.sv
`timescale 1ns/1ps
module acq_engine
    import acq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LEN_W     = 8,
    parameter int MAX_DELAY = 15,
    localparam int DLY_W    = $clog2(MAX_DELAY + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              arm_i,
    input  logic              src_sel_i,
    input  logic              strobe_clk_i,
    input  logic              fall_edge_i,
    input  logic [DLY_W-1:0]  dly_cycles_i,
    input  logic [LEN_W-1:0]  cap_len_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              gen_active_i,
    input  logic              ext_trig_i,
    output logic [DATA_W-1:0] cap_data_o,
    output logic              cap_valid_o,
    output logic              done_o,
    output logic              cfg_err_o
);
    logic [DATA_W-1:0] smp_q;
    logic              act_q, ext_rise, dly_act;
    logic [DLY_W-1:0]  dly_sel;
    acq_state_e        ctl_state;

    acq_sampler #(.DATA_W(DATA_W)) u_sampler (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fall_edge_i (fall_edge_i),
        .data_i      (smp_data_i),
        .act_i       (gen_active_i),
        .ext_i       (ext_trig_i),
        .data_o      (smp_q),
        .act_o       (act_q),
        .ext_rise_o  (ext_rise)
    );

    acq_delay_line #(.MAX_DELAY(MAX_DELAY)) u_delay (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .act_i  (act_q),
        .sel_i  (dly_sel),
        .act_o  (dly_act)
    );

    acq_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DLY_W(DLY_W)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .arm_i        (arm_i),
        .src_sel_i    (src_sel_i),
        .strobe_clk_i (strobe_clk_i),
        .dly_cycles_i (dly_cycles_i),
        .cap_len_i    (cap_len_i),
        .smp_i        (smp_q),
        .ext_rise_i   (ext_rise),
        .dly_act_i    (dly_act),
        .dly_sel_o    (dly_sel),
        .cap_data_o   (cap_data_o),
        .cap_valid_o  (cap_valid_o),
        .done_o       (done_o),
        .cfg_err_o    (cfg_err_o),
        .state_o      (ctl_state)
    );
endmodule

// File: rtl/acq_engine_chk.sv
`timescale 1ns/1ps
module acq_engine_chk
    import acq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             arm_i,
    input logic             src_sel_i,
    input logic             strobe_clk_i,
    input logic [LEN_W-1:0] cap_len_i,
    input logic             cap_valid_o,
    input logic             done_o,
    input logic             cfg_err_o,
    input acq_state_e       ctl_state
);
    logic             bad_cfg, arm_ok;
    logic [LEN_W:0]   seen_q;
    logic [LEN_W-1:0] want_q;

    assign bad_cfg = src_sel_i && strobe_clk_i;
    assign arm_ok  = arm_i && !bad_cfg &&
                     (ctl_state == ST_IDLE || ctl_state == ST_DONE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= '0;
            want_q <= '0;
        end else if (arm_ok) begin
            seen_q <= '0;
            want_q <= cap_len_i;
        end else if (cap_valid_o) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // R5: sample count at completion equals the length latched at arm
    p_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> (seen_q == {1'b0, want_q}));

    // R6: no sample is flagged while done is high
    p_valid_not_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_valid_o |-> !done_o);

    // R6: done holds until an arm request
    p_done_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !arm_i) |=> done_o);

    // R8: error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> cfg_err_o);

    // R8: conflicting arm is refused and flagged
    p_refuse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && bad_cfg && ctl_state == ST_IDLE) |=> (ctl_state == ST_IDLE && cfg_err_o));
endmodule

bind acq_engine acq_engine_chk #(.LEN_W(LEN_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .src_sel_i    (src_sel_i),
    .strobe_clk_i (strobe_clk_i),
    .cap_len_i    (cap_len_i),
    .cap_valid_o  (cap_valid_o),
    .done_o       (done_o),
    .cfg_err_o    (cfg_err_o),
    .ctl_state    (ctl_state)
);

// File: tb/acq_engine_tb_top.sv
`timescale 1ns/1ps
module acq_engine_tb_top;
    localparam int DATA_W = 8;
    localparam int LEN_W  = 8;
    localparam int DLY_W  = 4;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              arm_i = 1'b0;
    logic              src_sel_i = 1'b0;
    logic              strobe_clk_i = 1'b0;
    logic              fall_edge_i = 1'b1;
    logic [DLY_W-1:0]  dly_cycles_i = '0;
    logic [LEN_W-1:0]  cap_len_i = '0;
    logic [DATA_W-1:0] smp_data_i = '0;
    logic              gen_active_i = 1'b0;
    logic              ext_trig_i = 1'b0;
    logic [DATA_W-1:0] cap_data_o;
    logic              cap_valid_o, done_o, cfg_err_o;

    always #4 clk = ~clk;

    acq_engine dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .src_sel_i(src_sel_i),
        .strobe_clk_i(strobe_clk_i), .fall_edge_i(fall_edge_i),
        .dly_cycles_i(dly_cycles_i), .cap_len_i(cap_len_i),
        .smp_data_i(smp_data_i), .gen_active_i(gen_active_i),
        .ext_trig_i(ext_trig_i), .cap_data_o(cap_data_o),
        .cap_valid_o(cap_valid_o), .done_o(done_o), .cfg_err_o(cfg_err_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int loop_n = 0;
    bit gen_on = 1'b0;
    logic [7:0] ramp = '0;
    logic [7:0] gen_hist [64];
    logic [7:0] din_hist [64];
    logic [7:0] got [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: generator and external loop model update after the rising edge
    task automatic tick();
        @(posedge clk);
        #2;
        cyc++;
        if (gen_on) begin
            gen_hist[cyc % 64] = ramp;
            ramp++;
        end else begin
            gen_hist[cyc % 64] = 8'($urandom);
        end
        gen_active_i = gen_on;
        smp_data_i   = (cyc >= loop_n) ? gen_hist[(cyc - loop_n) % 64] : 8'h00;
        din_hist[cyc % 64] = smp_data_i;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cap_valid_o) got.push_back(cap_data_o);
        end
    end

    task automatic do_reset();
        rst_ni = 1'b0;
        repeat (3) tick();
        check(!cap_valid_o && !done_o && !cfg_err_o, "R1 outputs in reset",
              {cap_valid_o, done_o, cfg_err_o}, 0);
        rst_ni = 1'b1;
        repeat (2) tick();
        check(!cap_valid_o && !done_o && !cfg_err_o, "R1 outputs after reset",
              {cap_valid_o, done_o, cfg_err_o}, 0);
    endtask

    task automatic pulse_arm();
        got.delete();
        arm_i = 1'b1;
        tick();
        arm_i = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (done_o) break;
            tick();
        end
    endtask

    // wrapback: ramp sent through loop of latency n, delay set to n
    task automatic run_wrap(input int n, input int len, input bit fall, input string req);
        int bad;
        int first_bad;
        loop_n = n;
        src_sel_i = 1'b1; strobe_clk_i = 1'b0; fall_edge_i = fall;
        dly_cycles_i = DLY_W'(n); cap_len_i = LEN_W'(len);
        pulse_arm();
        repeat (3) tick();
        ramp = '0;
        gen_on = 1'b1;
        for (int i = 0; i < len + n + 20; i++) begin
            tick();
            if (i == len + n + 4) gen_on = 1'b0;
            if (done_o) break;
        end
        gen_on = 1'b0;
        wait_done(60);
        bad = 0; first_bad = -1;
        foreach (got[i]) if (got[i] != 8'(i)) begin
            bad++;
            if (first_bad < 0) first_bad = i;
        end
        check(got.size() == len, "R5 sample count", got.size(), len);
        check(bad == 0, req, (first_bad >= 0) ? int'(got[first_bad]) : 0,
              (first_bad >= 0) ? first_bad : 0);
        check(done_o, "R6 done after capture", done_o, 1);
        repeat (20) tick();
        check(done_o, "R6 done holds", done_o, 1);
    endtask

    task automatic run_ext(input int len, input bit fall);
        int t0;
        int bad;
        loop_n = 0;
        src_sel_i = 1'b0; strobe_clk_i = 1'b0; fall_edge_i = fall;
        cap_len_i = LEN_W'(len);
        pulse_arm();
        repeat (2 + ($urandom % 4)) tick();
        ext_trig_i = 1'b1;
        t0 = cyc;
        repeat (3) tick();
        ext_trig_i = 1'b0;
        wait_done(len + 20);
        bad = 0;
        foreach (got[i]) if (got[i] != din_hist[(t0 + i) % 64]) bad++;
        check(got.size() == len, "R5 count ext", got.size(), len);
        check(bad == 0, "R4 ext trigger alignment", bad, 0);
        check(done_o, "R6 done ext", done_o, 1);
        repeat (4) tick();
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();

        // R3: delay extremes
        run_wrap(0, 8, 1'b1, "R3 delay 0 wrapback");
        run_wrap(15, 12, 1'b1, "R3 delay 15 wrapback");

        // R6: accepted arm clears done
        src_sel_i = 1'b0; cap_len_i = 8'd4;
        arm_i = 1'b1; tick(); arm_i = 1'b0;
        check(!done_o, "R6 arm clears done", done_o, 0);
        ext_trig_i = 1'b1; repeat (2) tick(); ext_trig_i = 1'b0;
        wait_done(20);

        // R9: both sampling edges give identical alignment
        run_wrap(5, 10, 1'b0, "R9 rising-edge wrapback");
        run_wrap(5, 10, 1'b1, "R9 falling-edge wrapback");

        // R4: external trigger
        run_ext(6, 1'b1);
        run_ext(1, 1'b0);

        // R7: zero length
        src_sel_i = 1'b0; cap_len_i = 8'd0;
        pulse_arm();
        tick(); ext_trig_i = 1'b1; repeat (2) tick(); ext_trig_i = 1'b0;
        wait_done(20);
        check(done_o, "R7 done with zero length", done_o, 1);
        check(got.size() == 0, "R7 no samples", got.size(), 0);

        // R2: randomised loop latencies
        for (int k = 0; k < 10; k++) begin
            int n = $urandom % 16;
            int len = 1 + ($urandom % 40);
            run_wrap(n, len, 1'($urandom), "R2 wrapback ramp starts at 0");
        end

        // R8: conflicting configuration from idle
        do_reset();
        src_sel_i = 1'b1; strobe_clk_i = 1'b1; dly_cycles_i = 4'd2; cap_len_i = 8'd5;
        loop_n = 2;
        pulse_arm();
        check(cfg_err_o, "R8 error set", cfg_err_o, 1);
        strobe_clk_i = 1'b0;
        ramp = '0; gen_on = 1'b1;
        repeat (20) tick();
        gen_on = 1'b0;
        repeat (20) tick();
        check(got.size() == 0, "R8 refused arm captures nothing", got.size(), 0);
        check(!done_o, "R8 refused arm no done", done_o, 0);
        run_wrap(2, 5, 1'b1, "R2 capture after refused arm");
        check(cfg_err_o, "R8 error sticky", cfg_err_o, 1);
        do_reset();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule